// File: doc/BRIEF.md
# Radio Event Timer

This block is a free-running counter with a small bank of compare units and capture units, so that radio transmit and receive actions can be started at scheduled instants without the processor stepping in. The counter runs on its own slow timer clock. Compare units watch it and raise a one-cycle processor interrupt pulse and up to four hardware trigger pulses toward the radio state machines. Capture units record the counter value when a chosen radio event or a software request occurs.

Software configures the block through a plain word-addressed register port clocked by the fast bus clock. The timer clock is assumed to be derived from the bus clock and phase-aligned with it, with its edges falling on bus clock edges. Configuration fields are copied into the timer domain on every timer edge. One-shot requests such as counter reset and software capture cross as toggles. Compare and capture events cross back the same way and set sticky status bits in the bus domain. The `irq` output is the OR of all status bits.

Top module: `radio_event_timer`

## Requirements
- R1: After reset, the counter, all capture values, all status bits, `cmp_irq`, `cmp_trig` and `irq` are zero, the counter is stopped, and the wrap value (address 1) is all ones.
- R2: While the run bit (address 0, bit 0) is applied, the counter rises by one on each timer clock edge. While it is clear, the counter holds its value. The counter is readable at address 2 and on `tmr_count`.
- R3: On the edge after the counter equals the applied wrap value (address 1), it goes to zero instead of incrementing.
- R4: Writing 1 to address 0 bit 1 forces the counter to zero on the first timer edge after the write. That edge causes no compare match.
- R5: Writes to the run bit, the wrap value, compare values, output enables and capture selects are used by the timer from the second timer edge after the write.
- R6: Compare unit i holds a value at address 8+i. On a timer edge where the counter advances (not a forced reset) to a value equal to it, a compare match occurs. The match output is high for exactly the following timer cycle.
- R7: The enables of compare unit i are at address 12+i. Bit 0 gates `cmp_irq[i]`. Bits 1 to 4 gate `cmp_trig[4*i+0]` to `cmp_trig[4*i+3]`. A match on a disabled output leaves it low.
- R8: The capture select of unit j is at address 16+j. Bit 1+k selects a rising edge of `radio_evt[k]`, seen on a timer edge. The unit then stores the counter value held just before that edge, readable at address 20+j.
- R9: Writing 1 to bit j of address 4 requests a software capture on unit j at the first timer edge after the write. The request takes effect only if select bit 0 of that unit is set.
- R10: Status at address 3 has compare-interrupt bits in [NCMP-1:0], capture bits in [NCMP+NCAP-1:NCMP] and overflow bits above those. A bit is set by its event, cleared by writing 1 to it, and `irq` is high while any bit is set. A compare bit is set only when that unit's interrupt output is enabled.
- R11: A capture on unit j while its capture status bit is still set also sets overflow bit NCMP+NCAP+j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock for the register port and status |
| tclk | input | 1 | Timer clock, phase-aligned with bclk |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | CW | Write data |
| reg_rdata | output | CW | Read data for reg_addr (combinational) |
| radio_evt | input | 5 | Radio event lines, timer-clock synchronous |
| tmr_count | output | CW | Current counter value |
| cmp_irq | output | NCMP | Per-unit compare interrupt pulse, timer domain |
| cmp_trig | output | 4*NCMP | Per-unit trigger pulses toward radio state machines |
| irq | output | 1 | Processor interrupt, OR of status bits |

## Verification
A reference model in the bench steps once per timer rising edge. It uses the configuration applied at the previous edge and acts on counter reset, software capture and event requests at the current one. All register traffic is issued half a bus cycle after a timer falling edge, so every write lands well before the next timer edge. Counter, compare pulses and triggers are due one timer edge after the cause. Status bits and `irq` are due one bus cycle after that timer edge. All of them are sampled at the bus falling edge that follows the next timer falling edge. Register reads are made in that same slot, so both the counter and the status values have settled when they are compared.

// File: rtl/radio_event_timer.sv
module radio_event_timer #(
  parameter int CW   = 16,
  parameter int NCMP = 2,
  parameter int NCAP = 2
) (
  input  logic                 bclk,
  input  logic                 tclk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [4:0]           reg_addr,
  input  logic [CW-1:0]        reg_wdata,
  output logic [CW-1:0]        reg_rdata,
  input  logic [4:0]           radio_evt,
  output logic [CW-1:0]        tmr_count,
  output logic [NCMP-1:0]      cmp_irq,
  output logic [4*NCMP-1:0]    cmp_trig,
  output logic                 irq
);
  localparam int SW = NCMP + 2*NCAP;
  localparam logic [4:0] A_CTRL = 5'd0, A_WRAP = 5'd1, A_CNT = 5'd2,
                         A_STAT = 5'd3, A_SWC = 5'd4;

  logic            run_b, run_t, rst_tog_b, rst_tog_t, rst_ev;
  logic [CW-1:0]   wrap_b, wrap_t, cnt, cnt_nxt;
  logic [CW-1:0]   cmpv_b [NCMP];
  logic [CW-1:0]   cmpv_t [NCMP];
  logic [4:0]      oen_b  [NCMP];
  logic [4:0]      oen_t  [NCMP];
  logic [5:0]      sel_b  [NCAP];
  logic [5:0]      sel_t  [NCAP];
  logic [CW-1:0]   cap_t  [NCAP];
  logic [NCAP-1:0] sw_tog_b, sw_tog_t, fire, cap_tog_t, seen_cap, cap_new;
  logic [NCMP-1:0] hit, cmp_tog_t, seen_cmp, cmp_new;
  logic [4:0]      evt_q;
  logic [SW-1:0]   stat_b, stat_nxt, clr;

  assign tmr_count = cnt;
  assign irq       = |stat_b;
  assign cmp_new   = cmp_tog_t ^ seen_cmp;
  assign cap_new   = cap_tog_t ^ seen_cap;
  assign clr       = (reg_wr && reg_addr == A_STAT) ? reg_wdata[SW-1:0] : '0;

  always_comb begin
    stat_nxt = stat_b & ~clr;
    stat_nxt[NCMP-1:0] = stat_nxt[NCMP-1:0] | cmp_new;
    stat_nxt[NCMP+NCAP-1:NCMP] = stat_nxt[NCMP+NCAP-1:NCMP] | cap_new;
    stat_nxt[SW-1:NCMP+NCAP] = stat_nxt[SW-1:NCMP+NCAP]
                             | (cap_new & stat_b[NCMP+NCAP-1:NCMP] & ~clr[NCMP+NCAP-1:NCMP]);
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      run_b <= 1'b0; wrap_b <= '1; rst_tog_b <= 1'b0; sw_tog_b <= '0;
      stat_b <= '0; seen_cmp <= '0; seen_cap <= '0;
      for (int i = 0; i < NCMP; i++) begin cmpv_b[i] <= '0; oen_b[i] <= '0; end
      for (int j = 0; j < NCAP; j++) sel_b[j] <= '0;
    end else begin
      seen_cmp <= cmp_tog_t;
      seen_cap <= cap_tog_t;
      stat_b   <= stat_nxt;
      if (reg_wr) begin
        if (reg_addr == A_CTRL) begin
          run_b <= reg_wdata[0];
          if (reg_wdata[1]) rst_tog_b <= ~rst_tog_b;
        end
        if (reg_addr == A_WRAP) wrap_b <= reg_wdata;
        if (reg_addr == A_SWC) sw_tog_b <= sw_tog_b ^ reg_wdata[NCAP-1:0];
        for (int i = 0; i < NCMP; i++) begin
          if (reg_addr == 5'(8 + i))  cmpv_b[i] <= reg_wdata;
          if (reg_addr == 5'(12 + i)) oen_b[i]  <= reg_wdata[4:0];
        end
        for (int j = 0; j < NCAP; j++)
          if (reg_addr == 5'(16 + j)) sel_b[j] <= reg_wdata[5:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = CW'(run_b);
      A_WRAP:  reg_rdata = wrap_b;
      A_CNT:   reg_rdata = cnt;
      A_STAT:  reg_rdata = CW'(stat_b);
      default: ;
    endcase
    for (int i = 0; i < NCMP; i++) begin
      if (reg_addr == 5'(8 + i))  reg_rdata = cmpv_b[i];
      if (reg_addr == 5'(12 + i)) reg_rdata = CW'(oen_b[i]);
    end
    for (int j = 0; j < NCAP; j++) begin
      if (reg_addr == 5'(16 + j)) reg_rdata = CW'(sel_b[j]);
      if (reg_addr == 5'(20 + j)) reg_rdata = cap_t[j];
    end
  end

  always_comb begin
    rst_ev = rst_tog_b ^ rst_tog_t;
    if (rst_ev)     cnt_nxt = '0;
    else if (run_t) cnt_nxt = (cnt == wrap_t) ? '0 : cnt + CW'(1);
    else            cnt_nxt = cnt;
    for (int i = 0; i < NCMP; i++)
      hit[i] = run_t & ~rst_ev & (cnt_nxt == cmpv_t[i]);
    for (int j = 0; j < NCAP; j++)
      fire[j] = |({radio_evt & ~evt_q, sw_tog_b[j] ^ sw_tog_t[j]} & sel_t[j]);
  end

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) begin
      run_t <= 1'b0; wrap_t <= '1; rst_tog_t <= 1'b0; sw_tog_t <= '0; cnt <= '0;
      evt_q <= '0; cmp_irq <= '0; cmp_trig <= '0; cmp_tog_t <= '0; cap_tog_t <= '0;
      for (int i = 0; i < NCMP; i++) begin cmpv_t[i] <= '0; oen_t[i] <= '0; end
      for (int j = 0; j < NCAP; j++) begin sel_t[j] <= '0; cap_t[j] <= '0; end
    end else begin
      run_t <= run_b; wrap_t <= wrap_b; rst_tog_t <= rst_tog_b; sw_tog_t <= sw_tog_b;
      evt_q <= radio_evt;
      cnt   <= cnt_nxt;
      for (int i = 0; i < NCMP; i++) begin
        cmpv_t[i]    <= cmpv_b[i];
        oen_t[i]     <= oen_b[i];
        cmp_irq[i]   <= hit[i] & oen_t[i][0];
        cmp_tog_t[i] <= cmp_tog_t[i] ^ (hit[i] & oen_t[i][0]);
        for (int k = 0; k < 4; k++) cmp_trig[4*i+k] <= hit[i] & oen_t[i][k+1];
      end
      for (int j = 0; j < NCAP; j++) begin
        sel_t[j]     <= sel_b[j];
        cap_tog_t[j] <= cap_tog_t[j] ^ fire[j];
        if (fire[j]) cap_t[j] <= cnt;
      end
    end
  end

  a_r3_wrap_to_zero: assert property (@(posedge tclk) disable iff (!rst_n)
    (run_t && !rst_ev && cnt == wrap_t) |=> cnt == '0);
  a_r2_hold_when_stopped: assert property (@(posedge tclk) disable iff (!rst_n)
    (!run_t && !rst_ev) |=> $stable(cnt));
  a_r4_forced_zero: assert property (@(posedge tclk) disable iff (!rst_n)
    rst_ev |=> (cnt == '0 && cmp_irq == '0 && cmp_trig == '0));
  a_r10_clear_all: assert property (@(posedge bclk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STAT && reg_wdata[SW-1:0] == '1 && cmp_new == '0 && cap_new == '0)
      |=> stat_b == '0);

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp_chk
    a_r6_match_value: assert property (@(posedge tclk) disable iff (!rst_n)
      cmp_irq[i] |-> cnt == $past(cmpv_t[i]));
    for (genvar k = 0; k < 4; k++) begin : g_trig
      a_r7_trig_enabled: assert property (@(posedge tclk) disable iff (!rst_n)
        cmp_trig[4*i+k] |-> ($past(oen_t[i][k+1]) && cnt == $past(cmpv_t[i])));
    end
  end
  for (genvar j = 0; j < NCAP; j++) begin : g_cap_chk
    a_r11_ovf_needs_pending: assert property (@(posedge bclk) disable iff (!rst_n)
      $rose(stat_b[NCMP+NCAP+j]) |-> $past(stat_b[NCMP+j]));
  end
endmodule

// File: tb/radio_event_timer_test.sv
module radio_event_timer_test;
  logic bclk = 0, tclk = 0, rst_n = 0, reg_wr = 0;
  logic [4:0] reg_addr = '0, radio_evt = '0;
  logic [15:0] reg_wdata = '0, reg_rdata, tmr_count;
  logic [1:0] cmp_irq;
  logic [7:0] cmp_trig;
  logic irq;
  int n_chk = 0, n_bad = 0;

  radio_event_timer uut (.bclk, .tclk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .radio_evt, .tmr_count, .cmp_irq, .cmp_trig, .irq);

  initial begin
    int ph = 0;
    forever begin
      #10 bclk = 1;
      if (ph == 0) tclk = 1; else if (ph == 2) tclk = 0;
      ph = (ph + 1) % 4;
      #10 bclk = 0;
    end
  end

  logic        m_run = 0, m_run_t = 0, m_rstreq = 0;
  logic [15:0] m_wrap = '1, m_wrap_t = '1, m_cnt = 0;
  logic [15:0] m_cmp [2] = '{0, 0};
  logic [15:0] m_cmp_t [2] = '{0, 0};
  logic [15:0] m_cap [2] = '{0, 0};
  logic [4:0]  m_oen [2] = '{0, 0};
  logic [4:0]  m_oen_t [2] = '{0, 0};
  logic [5:0]  m_sel [2] = '{0, 0};
  logic [5:0]  m_sel_t [2] = '{0, 0};
  logic [1:0]  m_swreq = 0, e_irq = 0;
  logic [7:0]  e_trig = 0;
  logic [5:0]  m_stat = 0;
  logic [4:0]  m_evt = 0, m_evq = 0;

  always @(posedge tclk) begin
    if (rst_n) begin
      logic rev, adv, fire;
      logic [15:0] nxt;
      rev = m_rstreq; m_rstreq = 0;
      for (int j = 0; j < 2; j++) begin
        fire = (m_swreq[j] & m_sel_t[j][0]) | (|(m_sel_t[j][5:1] & m_evt & ~m_evq));
        if (fire) begin
          if (m_stat[2+j]) m_stat[4+j] = 1;
          m_stat[2+j] = 1;
          m_cap[j] = m_cnt;
        end
      end
      m_swreq = 0;
      adv = m_run_t && !rev;
      nxt = rev ? 16'd0 : (adv ? ((m_cnt == m_wrap_t) ? 16'd0 : m_cnt + 16'd1) : m_cnt);
      for (int i = 0; i < 2; i++) begin
        e_irq[i] = adv && nxt == m_cmp_t[i] && m_oen_t[i][0];
        if (e_irq[i]) m_stat[i] = 1;
        for (int k = 0; k < 4; k++) e_trig[4*i+k] = adv && nxt == m_cmp_t[i] && m_oen_t[i][k+1];
      end
      m_cnt = nxt; m_evq = m_evt;
      m_run_t = m_run; m_wrap_t = m_wrap;
      for (int i = 0; i < 2; i++) begin m_cmp_t[i] = m_cmp[i]; m_oen_t[i] = m_oen[i]; end
      for (int j = 0; j < 2; j++) m_sel_t[j] = m_sel[j];
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] m_read(logic [4:0] a);
    case (a)
      0: return {15'd0, m_run};
      1: return m_wrap;
      2: return m_cnt;
      3: return {10'd0, m_stat};
      8, 9: return m_cmp[a-8];
      12, 13: return {11'd0, m_oen[a-12]};
      16, 17: return {10'd0, m_sel[a-16]};
      20, 21: return m_cap[a-20];
      default: return 16'd0;
    endcase
  endfunction

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge tclk); @(negedge bclk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge bclk); reg_wr = 0;
    case (a)
      0: begin m_run = d[0]; if (d[1]) m_rstreq = 1; end
      1: m_wrap = d;
      3: m_stat = m_stat & ~d[5:0];
      4: m_swreq = m_swreq | d[1:0];
      8, 9: m_cmp[a-8] = d;
      12, 13: m_oen[a-12] = d[4:0];
      16, 17: m_sel[a-16] = d[5:0];
      default: ;
    endcase
  endtask

  task automatic rd(logic [4:0] a, string req);
    @(negedge tclk); @(negedge bclk);
    reg_addr = a; #1;
    chk(req, reg_rdata, m_read(a));
  endtask

  task automatic evt(logic [4:0] v);
    @(negedge tclk); @(negedge bclk);
    radio_evt = v; m_evt = v;
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    wait (rst_n);
    forever begin
      @(negedge tclk); @(negedge bclk);
      chk("R2 R5 count", tmr_count, m_cnt);
      chk("R6 cmp_irq", {14'd0, cmp_irq}, {14'd0, e_irq});
      chk("R7 cmp_trig", {8'd0, cmp_trig}, {8'd0, e_trig});
      chk("R10 irq", {15'd0, irq}, {15'd0, |m_stat});
    end
  end

  initial begin
    #4000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge bclk);
    rst_n = 1;
    // R1 reset state
    rd(5'd2, "R1 count");
    rd(5'd3, "R1 status");
    rd(5'd1, "R1 wrap");
    rd(5'd20, "R1 capture");
    chk("R1 irq", {15'd0, irq}, 16'd0);
    // R6 R7 directed compare setup, R3 wrap at 5
    wr(5'd1, 16'd5);
    wr(5'd8, 16'd3);
    wr(5'd12, 16'h01);
    wr(5'd9, 16'd5);
    wr(5'd13, 16'h06);
    wr(5'd0, 16'd1);
    repeat (16) @(negedge tclk);
    rd(5'd2, "R3 count after wraps");
    rd(5'd3, "R10 status after matches");
    wr(5'd3, 16'h3f);
    rd(5'd3, "R10 cleared");
    // R2 stop and hold
    wr(5'd0, 16'd0);
    repeat (3) @(negedge tclk);
    rd(5'd2, "R2 held count");
    // R4 forced zero while running
    wr(5'd0, 16'd1);
    repeat (3) @(negedge tclk);
    wr(5'd0, 16'd3);
    rd(5'd2, "R4 count after reset request");
    // R8 radio event capture, R11 overflow
    wr(5'd16, 16'h04);
    evt(5'b00010); evt(5'b00000);
    rd(5'd20, "R8 capture value");
    evt(5'b00010); evt(5'b00000);
    rd(5'd3, "R11 overflow flag");
    // R9 software capture, gated by select bit 0
    wr(5'd4, 16'd2);
    rd(5'd21, "R9 no capture when unselected");
    wr(5'd17, 16'h01);
    repeat (2) @(negedge tclk);
    wr(5'd4, 16'd2);
    rd(5'd21, "R9 software capture");
    wr(5'd3, 16'h3f);
    // random phase
    for (int n = 0; n < 600; n++) begin
      int op;
      op = $urandom % 9;
      case (op)
        0: wr(5'd0, {14'd0, ($urandom % 10 == 0), ($urandom % 5 != 0)});
        1: wr(5'd1, 16'(3 + $urandom % 10));
        2: wr(5'(8 + $urandom % 2), 16'($urandom % 13));
        3: wr(5'(12 + $urandom % 2), 16'($urandom % 32));
        4: wr(5'(16 + $urandom % 2), 16'($urandom % 64));
        5: evt(5'($urandom));
        6: wr(5'd4, 16'($urandom % 4));
        7: wr(5'd3, 16'($urandom % 64));
        default: begin
          int pick;
          pick = $urandom % 5;
          case (pick)
            0: rd(5'd3, "R10 R11 random status");
            1: rd(5'(20 + $urandom % 2), "R8 R9 random capture");
            2: rd(5'd2, "R2 R3 random count");
            3: rd(5'(8 + $urandom % 2), "R5 compare readback");
            default: rd(5'(16 + $urandom % 2), "R8 select readback");
          endcase
        end
      endcase
    end
    rd(5'd3, "R10 final status");
    finish_run();
  end
endmodule